// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the repeated-start condition of an I2C master. A one-cycle request pulse starts a fixed sequence of line moves. First SCL is pulled low. Then SDA is released. Then SCL is released. Both lines are held high together, and finally SDA is pulled low while SCL stays high. Each phase lasts one period of an internal reloadable baud timer. The block steps from one phase to the next only when the sampled line levels agree with what it drives. Because of this, a slave that holds SCL low simply lengthens the sequence. Another master that disagrees with the sequence causes a bus-collision abort.

The lines are open-drain. A drive-enable output of 1 pulls the line low, and 0 releases it. The resolved bus levels come back on the sampled inputs. While the sequence runs, `busy_o` is high. The surrounding logic uses it to hold off any other event-request writes, because requests cannot be queued. A write to the transmit buffer during the sequence is refused and flagged as a write collision. At the end, SDA is left pulled low so the first data bit can follow. A completion flag, a start-seen flag, a write-collision flag and a bus-collision flag are each cleared by their own write-one-to-clear strobe.

Top module: `rs_restart_seq`

## Requirements
- R1: A request pulse on `rs_req_i` is accepted only when the block is idle and `master_idle_i` is 1. A request made while `master_idle_i` is 0 leaves `busy_o`, `scl_oe_o` and `sda_oe_o` unchanged.
- R2: In the cycle after acceptance, `busy_o` and `scl_oe_o` are 1. Once SCL is sampled low, the timer loads `A` = `reload_i[5:0]`. `sda_oe_o` is then 0 and `scl_oe_o` is 1 for A+1 cycles.
- R3: At the end of that period, `scl_oe_o` drops to 0 only if SDA is sampled high. While SDA reads low, the block keeps SCL pulled low and waits.
- R4: After SCL is sampled high, the timer loads `B` = all seven bits of `reload_i`. Both lines are released for B+1 cycles. Then `sda_oe_o` is 1 with SCL released for B+1 cycles. With no stretching or collision, `busy_o` is high for exactly A + 2B + 5 cycles.
- R5: At completion, `busy_o` goes to 0, `sda_oe_o` stays 1 and `scl_oe_o` is 0. SDA remains pulled low until the next accepted sequence has sampled SCL low.
- R6: `start_flag_o` is set when sampled SDA falls while sampled SCL is high on both cycles. `done_flag_o` is set only when the final timer period expires, and stays 0 while `busy_o` is 1.
- R7: `buf_wr_ok_o` passes `txbuf_wr_i` through while idle. While busy it is 0, and a write attempt sets `wcol_flag_o`.
- R8: A second request made while `busy_o` is 1 has no effect: the sequence length is unchanged and no new sequence follows.
- R9: While waiting for SCL to be sampled high, the timer holds. Each cycle a slave holds SCL low lengthens the sequence by one cycle.
- R10: If SDA is sampled low in the cycle SCL is first sampled high after release, `bcol_flag_o` is set.
- R11: If SCL is sampled low during the both-high period, before SDA is pulled low, `bcol_flag_o` is set.
- R12: On a bus collision, both drive enables go to 0 and `busy_o` goes to 0 in the cycle the flag appears. `done_flag_o` is not set.
- R13: Synchronous active-high `rst` idles the block with both lines released and all flags 0. Each flag is cleared by a 1 on its own clear input, but a set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_req_i | input | 1 | One-cycle repeated-start request |
| master_idle_i | input | 1 | 1 when no other master bus event is in progress |
| reload_i | input | RLD_W (7) | Baud timer reload value; low FIRST_W bits used for the first period |
| txbuf_wr_i | input | 1 | Transmit buffer write attempt |
| sda_in_i | input | 1 | Sampled SDA level |
| scl_in_i | input | 1 | Sampled SCL level |
| clr_done_i | input | 1 | Write-one-to-clear for the completion flag |
| clr_start_i | input | 1 | Write-one-to-clear for the start-seen flag |
| clr_wcol_i | input | 1 | Write-one-to-clear for the write-collision flag |
| clr_bcol_i | input | 1 | Write-one-to-clear for the bus-collision flag |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| busy_o | output | 1 | Sequence in progress; event-request writes blocked |
| buf_wr_ok_o | output | 1 | Transmit buffer write allowed to land |
| done_flag_o | output | 1 | Sequence completed |
| start_flag_o | output | 1 | Start condition seen on the lines |
| wcol_flag_o | output | 1 | Buffer write refused during the sequence |
| bcol_flag_o | output | 1 | Bus collision during the sequence |

## Verification
Every cycle, the assertions check these things:
- a refused request leaves the block idle;
- an accepted one pulls SCL low first;
- SCL is released only after SDA read high;
- the stretch wait holds its state;
- both collision conditions abort into idle with the lines released;
- the completion flag rises only out of the final phase;
- write collisions and the flag clears behave as required.

Only the bench scenarios can show the exact phase lengths against the reload value over the whole 7-bit range, the extra cycles from a stretched clock, the SDA hold carried into the next sequence, and the fact that a request landing mid-sequence does not lengthen it.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SCL_DN,
        RS_SDA_UP,
        RS_SCL_UP,
        RS_BOTH_HI,
        RS_SDA_DN
    } rs_state_e;

    typedef struct packed {
        rs_state_e st;
        logic      hold_sda;
    } rs_ctl_s;

    typedef struct packed {
        logic sda;
        logic scl;
    } rs_lines_s;

    localparam int FLG_DONE  = 0;
    localparam int FLG_START = 1;
    localparam int FLG_WCOL  = 2;
    localparam int FLG_BCOL  = 3;
    localparam int FLG_N     = 4;

endpackage

// File: rtl/rs_baud_tmr.sv
`timescale 1ns/1ps
module rs_baud_tmr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         run_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (run_i && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // expired counter never wraps around
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !load_i && zero_o |=> zero_o); // R4
endmodule

// File: rtl/rs_line_mon.sv
`timescale 1ns/1ps
module rs_line_mon
    import rs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_o
);
    rs_lines_s prev_d, prev_q;

    always_comb begin
        prev_d.sda = sda_i;
        prev_d.scl = scl_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '{sda: 1'b1, scl: 1'b1};
        else     prev_q <= prev_d;
    end

    assign start_o = prev_q.sda && prev_q.scl && !sda_i && scl_i;
endmodule

// File: rtl/rs_flag_bank.sv
`timescale 1ns/1ps
module rs_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        for (int i = 0; i < N; i++)
            flag_d[i] = set_i[i] || (flag_q[i] && !clr_i[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    assign q_o = flag_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
            clr_i[g] && !set_i[g] |=> !q_o[g]); // R13
    end
endmodule

// File: rtl/rs_restart_seq.sv
`timescale 1ns/1ps
module rs_restart_seq
    import rs_pkg::*;
#(
    parameter int RLD_W   = 7,
    parameter int FIRST_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rs_req_i,
    input  logic             master_idle_i,
    input  logic [RLD_W-1:0] reload_i,
    input  logic             txbuf_wr_i,
    input  logic             sda_in_i,
    input  logic             scl_in_i,
    input  logic             clr_done_i,
    input  logic             clr_start_i,
    input  logic             clr_wcol_i,
    input  logic             clr_bcol_i,
    output logic             sda_oe_o,
    output logic             scl_oe_o,
    output logic             busy_o,
    output logic             buf_wr_ok_o,
    output logic             done_flag_o,
    output logic             start_flag_o,
    output logic             wcol_flag_o,
    output logic             bcol_flag_o
);
    localparam logic [RLD_W-1:0] LOW_MASK = RLD_W'((1 << FIRST_W) - 1);

    rs_ctl_s          ctl_d, ctl_q;
    logic             tmr_load, tmr_run, tmr_zero;
    logic [RLD_W-1:0] tmr_val;
    logic             bcol_set, done_set, start_seen;
    logic [FLG_N-1:0] flg_set, flg_clr, flg_q;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        tmr_val  = reload_i;
        bcol_set = 1'b0;
        done_set = 1'b0;
        case (ctl_q.st)
            RS_IDLE: begin
                if (rs_req_i && master_idle_i)
                    ctl_d.st = RS_SCL_DN;
            end
            RS_SCL_DN: begin
                if (!scl_in_i) begin
                    tmr_load       = 1'b1;
                    tmr_val        = reload_i & LOW_MASK;
                    ctl_d.hold_sda = 1'b0;
                    ctl_d.st       = RS_SDA_UP;
                end
            end
            RS_SDA_UP: begin
                tmr_run = 1'b1;
                if (tmr_zero && sda_in_i)
                    ctl_d.st = RS_SCL_UP;
            end
            RS_SCL_UP: begin
                if (scl_in_i) begin
                    if (!sda_in_i) begin
                        bcol_set = 1'b1;
                        ctl_d.st = RS_IDLE;
                    end else begin
                        tmr_load = 1'b1;
                        ctl_d.st = RS_BOTH_HI;
                    end
                end
            end
            RS_BOTH_HI: begin
                tmr_run = 1'b1;
                if (!scl_in_i) begin
                    bcol_set = 1'b1;
                    ctl_d.st = RS_IDLE;
                end else if (tmr_zero) begin
                    tmr_load = 1'b1;
                    ctl_d.st = RS_SDA_DN;
                end
            end
            RS_SDA_DN: begin
                tmr_run = 1'b1;
                if (tmr_zero) begin
                    done_set       = 1'b1;
                    ctl_d.hold_sda = 1'b1;
                    ctl_d.st       = RS_IDLE;
                end
            end
            default: ctl_d.st = RS_IDLE;
        endcase
        if (bcol_set)
            ctl_d.hold_sda = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: RS_IDLE, hold_sda: 1'b0};
        else     ctl_q <= ctl_d;
    end

    assign busy_o      = (ctl_q.st != RS_IDLE);
    assign scl_oe_o    = (ctl_q.st == RS_SCL_DN) || (ctl_q.st == RS_SDA_UP);
    assign sda_oe_o    = (ctl_q.st == RS_SDA_DN) || ctl_q.hold_sda;
    assign buf_wr_ok_o = txbuf_wr_i && !busy_o;

    rs_baud_tmr #(.W(RLD_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .run_i  (tmr_run),
        .zero_o (tmr_zero)
    );

    rs_line_mon u_mon (
        .clk     (clk),
        .rst     (rst),
        .sda_i   (sda_in_i),
        .scl_i   (scl_in_i),
        .start_o (start_seen)
    );

    always_comb begin
        flg_set            = '0;
        flg_set[FLG_DONE]  = done_set;
        flg_set[FLG_START] = start_seen;
        flg_set[FLG_WCOL]  = txbuf_wr_i && busy_o;
        flg_set[FLG_BCOL]  = bcol_set;
        flg_clr            = '0;
        flg_clr[FLG_DONE]  = clr_done_i;
        flg_clr[FLG_START] = clr_start_i;
        flg_clr[FLG_WCOL]  = clr_wcol_i;
        flg_clr[FLG_BCOL]  = clr_bcol_i;
    end

    rs_flag_bank #(.N(FLG_N)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (flg_set),
        .clr_i (flg_clr),
        .q_o   (flg_q)
    );

    assign done_flag_o  = flg_q[FLG_DONE];
    assign start_flag_o = flg_q[FLG_START];
    assign wcol_flag_o  = flg_q[FLG_WCOL];
    assign bcol_flag_o  = flg_q[FLG_BCOL];

    AST_REQ_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == RS_IDLE) && rs_req_i && !master_idle_i |=> !busy_o); // R1
    AST_SCL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == RS_IDLE) && rs_req_i && master_idle_i |=> busy_o && scl_oe_o); // R2
    AST_SCL_REL_SDA_HI: assert property (@(posedge clk) disable iff (rst)
        busy_o && $fell(scl_oe_o) |-> $past(sda_in_i)); // R3
    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == RS_SCL_UP) && !scl_in_i |=> (ctl_q.st == RS_SCL_UP)); // R9
    AST_BCOL_RISE: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == RS_SCL_UP) && scl_in_i && !sda_in_i |=> bcol_flag_o && !busy_o); // R10
    AST_BCOL_EARLY_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == RS_BOTH_HI) && !scl_in_i |=> bcol_flag_o && !busy_o); // R11
    AST_BCOL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(bcol_flag_o) |-> !sda_oe_o && !scl_oe_o && !$rose(done_flag_o)); // R12
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag_o) |-> $past(ctl_q.st == RS_SDA_DN) && sda_oe_o && !busy_o); // R6
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
        txbuf_wr_i && busy_o |=> wcol_flag_o); // R7
    AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(start_flag_o) |-> $past(scl_in_i && !sda_in_i)); // R6
endmodule

// File: tb/sim_rs_restart_seq.sv
`timescale 1ns/1ps
module sim_rs_restart_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rs_req = 1'b0, midle = 1'b1, txw = 1'b0;
    logic [6:0] reload = '0;
    logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic       c_done = 1'b0, c_start = 1'b0, c_wcol = 1'b0, c_bcol = 1'b0;
    logic       sda_oe, scl_oe, busy, buf_ok, f_done, f_start, f_wcol, f_bcol;
    logic       sda_line, scl_line;
    int         n_cmp = 0, n_bad = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    assign sda_line = !sda_oe && !ext_sda_low;
    assign scl_line = !scl_oe && !ext_scl_low;

    rs_restart_seq u0 (
        .clk(clk), .rst(rst), .rs_req_i(rs_req), .master_idle_i(midle),
        .reload_i(reload), .txbuf_wr_i(txw), .sda_in_i(sda_line),
        .scl_in_i(scl_line), .clr_done_i(c_done), .clr_start_i(c_start),
        .clr_wcol_i(c_wcol), .clr_bcol_i(c_bcol), .sda_oe_o(sda_oe),
        .scl_oe_o(scl_oe), .busy_o(busy), .buf_wr_ok_o(buf_ok),
        .done_flag_o(f_done), .start_flag_o(f_start), .wcol_flag_o(f_wcol),
        .bcol_flag_o(f_bcol)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        c_done = 1; c_start = 1; c_wcol = 1; c_bcol = 1;
        @(negedge clk);
        c_done = 0; c_start = 0; c_wcol = 0; c_bcol = 0;
    endtask

    // Run one sequence; stretch K cycles at SCL release; pulse request again
    // at busy index again_at; write buffer at busy index wr_at.
    task automatic run_seq(input int r, input int k_str, input int again_at,
                           input int wr_at, output int dur, output int s0,
                           output int d1, output int done_busy, output int ok_at_wr);
        int  k = 0;
        bit  str_done = 0;
        s0 = 0; d1 = 0; done_busy = 0; ok_at_wr = -1;
        @(negedge clk);
        reload = 7'(r);
        rs_req = 1;
        @(negedge clk);
        rs_req = 0;
        while (busy) begin
            if (k == 0) s0 = int'(scl_oe);
            if (k == 1) d1 = int'(sda_oe);
            if (f_done) done_busy = 1;
            rs_req = (k == again_at);
            txw = (k == wr_at);
            if (k == wr_at) ok_at_wr = int'(buf_ok);
            if (k_str > 0 && !str_done && !scl_oe) begin
                ext_scl_low = 1;
                repeat (k_str) @(negedge clk);
                rs_req = 0; txw = 0;
                ext_scl_low = 0;
                k += k_str;
                str_done = 1;
            end
            k++;
            @(negedge clk);
        end
        rs_req = 0; txw = 0;
        dur = k;
    endtask

    initial begin
        int dur, s0, d1, db, okw;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R13 reset state
        check("R13 busy after reset", busy, 0);
        check("R13 sda_oe after reset", sda_oe, 0);
        check("R13 scl_oe after reset", scl_oe, 0);
        check("R13 flags after reset", {f_done, f_start, f_wcol, f_bcol}, 0);

        // R2 R4 R5 R6: full sweep of reload values
        for (int r = 0; r < 128; r++) begin
            clear_all();
            run_seq(r, 0, -1, -1, dur, s0, d1, db, okw);
            check("R4 sequence length", dur, (r % 64) + 2 * r + 5);
            check("R2 SCL pulled first", s0, 1);
            check("R5 SDA hold released after SCL low", d1, 0);
            check("R6 done flag stays low while busy", db, 0);
            check("R6 done flag at completion", f_done, 1);
            check("R6 start seen", f_start, 1);
            check("R5 SDA held low at end", sda_oe, 1);
            check("R5 SCL released at end", scl_oe, 0);
        end

        // R1: refused when master not idle
        midle = 0;
        rs_req = 1;
        @(negedge clk);
        rs_req = 0;
        check("R1 busy with master busy", busy, 0);
        check("R1 scl_oe unchanged", scl_oe, 0);
        check("R1 sda_oe unchanged", sda_oe, 1);
        @(negedge clk);
        check("R1 still idle", busy, 0);
        midle = 1;

        // R8: second request mid-sequence ignored
        run_seq(5, 0, 3, -1, dur, s0, d1, db, okw);
        check("R8 length with extra request", dur, 5 + 10 + 5);
        repeat (2) @(negedge clk);
        check("R8 no new sequence", busy, 0);

        // R7: write collision
        clear_all();
        run_seq(4, 0, -1, 2, dur, s0, d1, db, okw);
        check("R7 buffer write blocked while busy", okw, 0);
        check("R7 write collision flag", f_wcol, 1);
        clear_all();
        txw = 1;
        #1;
        check("R7 buffer write allowed idle", buf_ok, 1);
        @(negedge clk);
        txw = 0;
        check("R7 no collision idle", f_wcol, 0);

        // R9: clock stretch of 7 cycles
        run_seq(4, 7, -1, -1, dur, s0, d1, db, okw);
        check("R9 stretched length", dur, 4 + 8 + 5 + 7);

        // R3: SDA held low externally at end of first period
        clear_all();
        ext_sda_low = 1;
        @(negedge clk);
        reload = 7'd2;
        rs_req = 1;
        @(negedge clk);
        rs_req = 0;
        repeat (10) @(negedge clk);
        check("R3 SCL kept low while SDA low", scl_oe, 1);
        check("R3 still busy", busy, 1);
        ext_sda_low = 0;
        @(negedge clk);
        check("R3 SCL released once SDA high", scl_oe, 0);
        while (busy) @(negedge clk);
        check("R3 completes", f_done, 1);

        // R10 R12: SDA low at SCL rise
        clear_all();
        ext_scl_low = 1;
        @(negedge clk);
        reload = 7'd3;
        rs_req = 1;
        @(negedge clk);
        rs_req = 0;
        while (!(busy && !scl_oe)) @(negedge clk);
        ext_sda_low = 1;
        repeat (2) @(negedge clk);
        ext_scl_low = 0;
        @(negedge clk);
        check("R10 bus collision at rise", f_bcol, 1);
        check("R12 busy cleared", busy, 0);
        check("R12 lines released", {sda_oe, scl_oe}, 0);
        check("R12 no done flag", f_done, 0);
        ext_sda_low = 0;

        // R11 R12: SCL low during both-high period
        clear_all();
        @(negedge clk);
        reload = 7'd3;
        rs_req = 1;
        @(negedge clk);
        rs_req = 0;
        while (!(busy && !scl_oe)) @(negedge clk);
        @(negedge clk);
        ext_scl_low = 1;
        @(negedge clk);
        ext_scl_low = 0;
        check("R11 bus collision early SCL low", f_bcol, 1);
        check("R12 busy cleared", busy, 0);
        check("R12 lines released", {sda_oe, scl_oe}, 0);
        check("R12 no done flag", f_done, 0);

        // R13: individual W1C and set-over-clear
        clear_all();
        run_seq(1, 0, -1, 1, dur, s0, d1, db, okw);
        c_done = 1;
        @(negedge clk);
        c_done = 0;
        check("R13 done cleared", f_done, 0);
        check("R13 start kept", f_start, 1);
        check("R13 wcol kept", f_wcol, 1);
        c_wcol = 1;
        @(negedge clk);
        c_wcol = 0;
        check("R13 wcol cleared", f_wcol, 0);
        check("R13 start still kept", f_start, 1);
        reload = 7'd6;
        rs_req = 1;
        @(negedge clk);
        rs_req = 0;
        txw = 1; c_wcol = 1;
        @(negedge clk);
        txw = 0; c_wcol = 0;
        check("R13 set wins over clear", f_wcol, 1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R13 reset mid-sequence busy", busy, 0);
        check("R13 reset mid-sequence lines", {sda_oe, scl_oe}, 0);
        check("R13 reset mid-sequence flags", {f_done, f_start, f_wcol, f_bcol}, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule